// File: doc/BRIEF.md
# Dual-Device Programmed-I/O Cycle Timer

This block times programmed-I/O transfers on a disk channel that carries two devices. It stores two timing sets, A and B. Each set has one byte for read cycles and one byte for write cycles. A shared configuration byte holds the address-setup length, a hardware read-prefetch enable and a ready-sample delay. A mapping byte decides which timing set serves device 1.

When the channel controller raises a cycle request, it also gives a device select and a direction. The block then runs three phases: address setup, strobe pulse and recovery. All lengths are counted in bus clocks and taken from the stored fields. At the end of the cycle the block raises a one-clock done flag.

Every field is stored below the clock count it stands for by a fixed offset. Setup and pulse are stored minus one, recovery minus two and the ready delay minus two. As a result, the all-zero reset contents give the shortest legal cycle.

Top module: `pio_cycle_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, address-valid, both strobes and done are low, prefetch enable is low and the ready delay reads 2.
- R2: A request accepted at a clock edge makes address-valid high with both strobes low for exactly (configuration bits 5:4)+1 clocks.
- R3: After setup, exactly one strobe is high for (timing byte bits 7:4)+1 consecutive clocks. The read strobe is used for a read request and the write strobe for a write request, and address-valid stays high throughout.
- R4: After the strobe drops, busy and address-valid stay high with both strobes low for (timing byte bits 3:0)+2 clocks.
- R5: Done is high for exactly one clock, the clock after recovery ends, with busy low. A request is accepted only while busy is low, including in the done clock; a request raised while busy is high has no effect.
- R6: The register address map is 0 = set A read, 1 = set A write, 2 = set B read, 3 = set B write, 4 = configuration, 5 = mapping. Writes to addresses 6 and 7 change nothing.
- R7: When mapping bit 0 is 1 (for example the value 0x85), device 0 uses set A and device 1 uses set B. When it is 0, which is the reset value, both devices use set A.
- R8: A read cycle uses the read byte of the selected set, and a write cycle uses the write byte.
- R9: All timing fields are captured when a request is accepted. A register write during a cycle does not change the current cycle; it applies to the next one.
- R10: The prefetch-enable output equals configuration bit 6.
- R11: The ready-delay output equals (configuration bits 2:1)+2, which gives a range of 2 to 5.
- R12: The read and write strobes are never high together, and neither is high outside the pulse phase.
- R13: With reset contents, a cycle takes 1 clock of setup, 1 clock of pulse and 2 clocks of recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| cyc_req | input | 1 | Cycle request |
| cyc_dev | input | 1 | Device select for the request (0 or 1) |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_busy | output | 1 | Cycle in progress (setup, pulse or recovery) |
| cyc_addr_valid | output | 1 | Address valid to the devices |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| cyc_done | output | 1 | One-clock end-of-cycle flag |
| prefetch_en | output | 1 | Hardware read-prefetch enable |
| ready_dly | output | 3 | Ready-sample delay in clocks |

## Verification
The bench checks the field boundaries:
- A pulse field of 15 gives 16 clocks of pulse.
- A recovery field of 15 gives 17 clocks of recovery.
- All-zero contents give 1/1/2 clocks.

A design with an off-by-one offset would stretch or shorten one phase by a clock.

The bench writes a timing byte in the middle of a cycle. A timer that reads its registers live, instead of capturing them at acceptance, would change that cycle's pulse or recovery. It also holds the request high through several cycles. A design that accepted a request early would cut recovery short, and one that accepted late would leave a gap after done.

Finally, device 1 is run both before and after the mapping byte is written, and with addresses 6 and 7 written. A design that decodes the set or the address map wrongly would time the cycle from the wrong byte.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

    localparam int TFLD_W  = 4;   // width of pulse and recovery fields
    localparam int SFLD_W  = 2;   // width of setup field
    localparam int RFLD_W  = 2;   // width of ready-delay field
    localparam int RDY_W   = 3;   // width of decoded ready delay
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 8;

    // longest phase is recovery: 2**TFLD_W + 1 clocks, counter holds len-1
    localparam int CNT_W   = $clog2(2**TFLD_W + 2);

    localparam logic [ADDR_W-1:0] ADDR_CFG = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_MAP = 3'd5;

    localparam int CFG_PREF_BIT = 6;
    localparam int CFG_SET_LO   = 4;
    localparam int CFG_RDY_LO   = 1;
    localparam int MAP_SPLIT    = 0;

    typedef struct packed {
        logic [TFLD_W-1:0] pulse_m1;
        logic [TFLD_W-1:0] rec_m2;
    } cyc_timing_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_RECOV = 2'd3
    } phase_t;

    // counter preload for the recovery phase: (rec_m2 + 2) - 1
    function automatic logic [CNT_W-1:0] rec_preload(input logic [TFLD_W-1:0] f);
        return CNT_W'(f) + CNT_W'(1);
    endfunction

    function automatic logic [RDY_W-1:0] ready_decode(input logic [RFLD_W-1:0] f);
        return RDY_W'(f) + RDY_W'(2);
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_timer_pkg::*;
#(
    parameter int N_SETS = 2,
    parameter int N_DIRS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sel_dev,
    input  logic              sel_wr,
    output cyc_timing_t       sel_tim,
    output logic [SFLD_W-1:0] setup_m1,
    output logic              prefetch_en,
    output logic [RDY_W-1:0]  ready_dly
);

    localparam int N_TIM = N_SETS * N_DIRS;

    cyc_timing_t       tim_q [N_TIM];
    logic [SFLD_W-1:0] setup_q;
    logic [RFLD_W-1:0] rdy_q;
    logic              pref_q;
    logic              split_q;

    // index = set*2 + direction, matching the address map
    for (genvar g = 0; g < N_TIM; g++) begin : g_tim
        always_ff @(posedge clk) begin
            if (rst)
                tim_q[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                tim_q[g] <= cyc_timing_t'(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q <= '0;
            rdy_q   <= '0;
            pref_q  <= 1'b0;
            split_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CFG) begin
                setup_q <= wr_data[CFG_SET_LO +: SFLD_W];
                rdy_q   <= wr_data[CFG_RDY_LO +: RFLD_W];
                pref_q  <= wr_data[CFG_PREF_BIT];
            end
            if (wr_addr == ADDR_MAP)
                split_q <= wr_data[MAP_SPLIT];
        end
    end

    logic use_b;
    assign use_b       = split_q & sel_dev;
    assign sel_tim     = tim_q[{use_b, sel_wr}];
    assign setup_m1    = setup_q;
    assign prefetch_en = pref_q;
    assign ready_dly   = ready_decode(rdy_q);

    assert_prefetch_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CFG) |=> (prefetch_en == $past(wr_data[CFG_PREF_BIT])));

    assert_ready_range_R11: assert property (@(posedge clk) disable iff (rst)
        (ready_dly >= RDY_W'(2)) && (ready_dly <= RDY_W'(5)));

    assert_unmapped_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > ADDR_MAP) |=> ($stable(prefetch_en) && $stable(ready_dly)));

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
    import pio_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_wr,
    input  cyc_timing_t       tim,
    input  logic [SFLD_W-1:0] setup_m1,
    output logic              busy,
    output logic              addr_valid,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              done
);

    phase_t            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [TFLD_W-1:0] pulse_q;
    logic [TFLD_W-1:0] rec_q;
    logic              wr_q;
    logic              done_q;
    logic              last;

    assign last = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            pulse_q <= '0;
            rec_q   <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (req) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= CNT_W'(setup_m1);
                        pulse_q <= tim.pulse_m1;
                        rec_q   <= tim.rec_m2;
                        wr_q    <= req_wr;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        phase_q <= PH_PULSE;
                        cnt_q   <= CNT_W'(pulse_q);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_PULSE: begin
                    if (last) begin
                        phase_q <= PH_RECOV;
                        cnt_q   <= rec_preload(rec_q);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_RECOV: begin
                    if (last) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy       = (phase_q != PH_IDLE);
    assign addr_valid = busy;
    assign rd_stb     = (phase_q == PH_PULSE) && !wr_q;
    assign wr_stb     = (phase_q == PH_PULSE) && wr_q;
    assign done       = done_q;

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_follows_busy_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_accept_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(req) && !$past(busy)));

    assert_strobe_after_setup_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_stb || wr_stb) |-> $past(addr_valid));

    assert_setup_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SETUP) |-> (cnt_q < CNT_W'(2**SFLD_W)));

    assert_dir_held_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(wr_q));

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
    import pio_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              cyc_req,
    input  logic              cyc_dev,
    input  logic              cyc_write,
    output logic              cyc_busy,
    output logic              cyc_addr_valid,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              cyc_done,
    output logic              prefetch_en,
    output logic [RDY_W-1:0]  ready_dly
);

    cyc_timing_t       sel_tim;
    logic [SFLD_W-1:0] setup_m1;

    pio_timing_regs #(
        .N_SETS (2),
        .N_DIRS (2)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_we),
        .wr_addr     (reg_addr),
        .wr_data     (reg_wdata),
        .sel_dev     (cyc_dev),
        .sel_wr      (cyc_write),
        .sel_tim     (sel_tim),
        .setup_m1    (setup_m1),
        .prefetch_en (prefetch_en),
        .ready_dly   (ready_dly)
    );

    pio_cycle_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (cyc_req),
        .req_wr     (cyc_write),
        .tim        (sel_tim),
        .setup_m1   (setup_m1),
        .busy       (cyc_busy),
        .addr_valid (cyc_addr_valid),
        .rd_stb     (rd_strobe),
        .wr_stb     (wr_strobe),
        .done       (cyc_done)
    );

    assert_no_strobe_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe || wr_strobe) |-> cyc_addr_valid);

    assert_recov_after_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_strobe || wr_strobe) |-> cyc_busy);

endmodule

// File: tb/pio_cycle_timer_bench.sv
module pio_cycle_timer_bench;

    typedef struct packed {
        logic       av;
        logic       rd;
        logic       wr;
        logic       busy;
        logic       done;
        logic [2:0] ph;   // 0 idle, 1 setup, 2 pulse, 3 recovery, 4 done
    } exp_t;

    localparam exp_t IDLE_E = '{av:1'b0, rd:1'b0, wr:1'b0, busy:1'b0, done:1'b0, ph:3'd0};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       cyc_req = 1'b0;
    logic       cyc_dev = 1'b0;
    logic       cyc_write = 1'b0;
    logic       cyc_busy, cyc_addr_valid, rd_strobe, wr_strobe, cyc_done, prefetch_en;
    logic [2:0] ready_dly;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    n_cycles = 0;
    string sect     = "R1 R13 reset state and minimum cycle";

    always #10 clk = ~clk;   // 50 MHz

    pio_cycle_timer u_pio_cycle_timer (
        .clk            (clk),
        .rst            (rst),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .cyc_req        (cyc_req),
        .cyc_dev        (cyc_dev),
        .cyc_write      (cyc_write),
        .cyc_busy       (cyc_busy),
        .cyc_addr_valid (cyc_addr_valid),
        .rd_strobe      (rd_strobe),
        .wr_strobe      (wr_strobe),
        .cyc_done       (cyc_done),
        .prefetch_en    (prefetch_en),
        .ready_dly      (ready_dly)
    );

    // ---------------- reference model ----------------
    exp_t       exp_q[$];
    exp_t       cur = IDLE_E;
    logic [7:0] m_tim [4];
    logic [7:0] m_cfg = 8'h00;
    logic       m_split = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
            cur = IDLE_E;
            for (int i = 0; i < 4; i++) m_tim[i] = 8'h00;
            m_cfg   = 8'h00;
            m_split = 1'b0;
        end else begin
            if (cyc_req && !cur.busy) begin
                int   idx;
                int   s, p, r;
                exp_t e;
                idx = ((m_split && cyc_dev) ? 2 : 0) + (cyc_write ? 1 : 0);
                s = int'(m_cfg[5:4]) + 1;
                p = int'(m_tim[idx][7:4]) + 1;
                r = int'(m_tim[idx][3:0]) + 2;
                for (int k = 0; k < s; k++) begin
                    e = '{av:1'b1, rd:1'b0, wr:1'b0, busy:1'b1, done:1'b0, ph:3'd1};
                    exp_q.push_back(e);
                end
                for (int k = 0; k < p; k++) begin
                    e = '{av:1'b1, rd:!cyc_write, wr:cyc_write, busy:1'b1, done:1'b0, ph:3'd2};
                    exp_q.push_back(e);
                end
                for (int k = 0; k < r; k++) begin
                    e = '{av:1'b1, rd:1'b0, wr:1'b0, busy:1'b1, done:1'b0, ph:3'd3};
                    exp_q.push_back(e);
                end
                e = '{av:1'b0, rd:1'b0, wr:1'b0, busy:1'b0, done:1'b1, ph:3'd4};
                exp_q.push_back(e);
            end
            if (exp_q.size() > 0) cur = exp_q.pop_front();
            else                  cur = IDLE_E;
            if (reg_we) begin
                case (reg_addr)
                    3'd0, 3'd1, 3'd2, 3'd3: m_tim[reg_addr[1:0]] = reg_wdata;
                    3'd4: m_cfg = reg_wdata;
                    3'd5: m_split = reg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    function automatic string phase_tag(input logic [2:0] ph);
        case (ph)
            3'd1:    return "R2";
            3'd2:    return "R3 R8 R12";
            3'd3:    return "R4";
            3'd4:    return "R5";
            default: return "R1 R5";
        endcase
    endfunction

    // ---------------- comparison on every clock ----------------
    always @(negedge clk) begin
        logic [4:0] act, expv;
        logic [2:0] rdy_exp;
        act  = {cyc_addr_valid, rd_strobe, wr_strobe, cyc_busy, cyc_done};
        expv = {cur.av, cur.rd, cur.wr, cur.busy, cur.done};
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s [%s] t=%0t av/rd/wr/busy/done actual=%b expected=%b",
                     phase_tag(cur.ph), sect, $time, act, expv);
        end
        n_checks++;
        if (prefetch_en !== m_cfg[6]) begin
            n_fail++;
            $display("FAIL R10 [%s] prefetch actual=%b expected=%b", sect, prefetch_en, m_cfg[6]);
        end
        rdy_exp = {1'b0, m_cfg[2:1]} + 3'd2;
        n_checks++;
        if (ready_dly !== rdy_exp) begin
            n_fail++;
            $display("FAIL R11 [%s] ready_dly actual=%0d expected=%0d", sect, ready_dly, rdy_exp);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles == 50000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d cycles expected fewer", n_cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic run_cyc(input logic dev, input logic w);
        @(negedge clk);
        cyc_req = 1'b1; cyc_dev = dev; cyc_write = w;
        @(negedge clk);
        cyc_req = 1'b0;
        while (cyc_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        sect = "R13 minimum timing from reset contents";
        run_cyc(1'b0, 1'b0);
        run_cyc(1'b1, 1'b1);

        sect = "R2 R3 R4 R10 setup 3 pulse 3 recovery 5";
        wreg(3'd4, 8'h60);
        wreg(3'd0, 8'h23);
        run_cyc(1'b0, 1'b0);

        sect = "R8 write byte of set A, max recovery 17";
        wreg(3'd1, 8'h4F);
        run_cyc(1'b0, 1'b1);
        run_cyc(1'b0, 1'b0);

        sect = "R7 device 1 on set A before mapping";
        wreg(3'd2, 8'hF0);
        wreg(3'd3, 8'h71);
        run_cyc(1'b1, 1'b0);

        sect = "R7 mapping 0x85 puts device 1 on set B, max pulse 16";
        wreg(3'd5, 8'h85);
        run_cyc(1'b1, 1'b0);
        run_cyc(1'b1, 1'b1);
        run_cyc(1'b0, 1'b1);

        sect = "R11 ready delay and setup 2";
        wreg(3'd4, 8'h16);
        run_cyc(1'b0, 1'b0);
        wreg(3'd4, 8'h32);
        run_cyc(1'b1, 1'b0);

        sect = "R6 writes to addresses 6 and 7 ignored";
        wreg(3'd6, 8'hFF);
        wreg(3'd7, 8'hFF);
        run_cyc(1'b0, 1'b0);
        run_cyc(1'b1, 1'b1);

        sect = "R9 register write during a cycle";
        @(negedge clk);
        cyc_req = 1'b1; cyc_dev = 1'b0; cyc_write = 1'b0;
        @(negedge clk);
        cyc_req = 1'b0;
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h5A;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h00;
        @(negedge clk);
        reg_we = 1'b0;
        while (cyc_busy) @(negedge clk);
        @(negedge clk);
        run_cyc(1'b0, 1'b0);

        sect = "R5 request held high, back-to-back and while busy";
        @(negedge clk);
        cyc_req = 1'b1; cyc_dev = 1'b1; cyc_write = 1'b0;
        repeat (70) @(negedge clk);
        cyc_write = 1'b1;
        repeat (40) @(negedge clk);
        cyc_req = 1'b0;
        while (cyc_busy) @(negedge clk);
        repeat (3) @(negedge clk);

        sect = "R1 reset restores idle state";
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        run_cyc(1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule